// File: doc/BRIEF.md
# Accumulator Read-After-Write Interlock

This block decides when an in-order operand pipeline must hold an instruction that reads a multiply-accumulate accumulator. Each instruction arrives as an abstract class code and a 2-bit accumulator index on a valid/ready stream. The block keeps the class and target of the last instruction that actually issued. It lowers `in_ready` only when a store-from-accumulator would read an accumulator that the previous instruction is still writing.

The stall is qualified by the accumulator index. A store from any other accumulator issues at once. A load-to-accumulator never waits. When a real hazard exists, the pipeline is held for a fixed window of two cycles, and the instruction issues on the cycle after that window.

Back-pressure rules: an instruction issues on a clock edge where both `in_valid` and `in_ready` are high. While `in_valid` is high and `in_ready` is low, the producer must keep `in_valid`, `in_class` and `in_acc` unchanged. A cycle with `in_valid` low is a bubble. `stall_req` is the same condition as `!in_ready`, provided as a plain control pin for the pipeline's hold logic.

Top module: `acc_stall_ctl`

## Requirements
- R1: After a synchronous active-high reset, the remembered instruction is "none". A store of any accumulator presented first issues with `stall_req` low.
- R2: A store (class code 3) of accumulator N, presented right after an issued MAC (code 1) targeting N, sees `stall_req` high and `in_ready` low for exactly two cycles. It issues on the third cycle.
- R3: A store of accumulator N, presented right after an issued load-to-accumulator (code 2) targeting N, is held for exactly two cycles.
- R4: A store of accumulator M, presented right after a MAC or load-to-accumulator that targeted a different accumulator N, issues with zero stall cycles.
- R5: A load-to-accumulator never stalls, whatever the previous instruction was.
- R6: Two back-to-back MACs to one accumulator, followed by a store of a different accumulator, give zero stall cycles.
- R7: Only the instruction immediately before counts. An issued non-writing instruction (code 4) or a bubble cycle between the writer and the store removes the hazard.
- R8: The remembered instruction changes only when an instruction issues or a bubble occurs, and it is unchanged while a store is held. A store that has issued is not a writer, so a second store of the same accumulator right after it does not stall.
- R9: `in_ready` is low only during a hazard stall window. On every other cycle it is high.
- R10: Class codes 5, 6 and 7 act as a non-writing instruction. They never stall, and they clear a pending hazard like code 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_class | input | 3 | Class code: 0 none, 1 MAC, 2 load-to-accumulator, 3 store-from-accumulator, 4 other |
| in_acc | input | 2 | Accumulator index used by the instruction |
| in_ready | output | 1 | Pipeline accepts the instruction this cycle |
| stall_req | output | 1 | Hold request to the operand pipeline |

## Verification
The assertions check the following on every cycle:
- the remembered instruction holds while a store waits, and resets to "none" after a bubble;
- the stall window starts at count one and always releases at its end;
- a rising stall always comes from a store whose index matches the remembered writer;
- a load-to-accumulator is never held.

Only the bench's scenarios can show the rest:
- that each hazard lasts exactly two cycles from the pipeline's view;
- that mismatched indices, back-to-back MACs, intervening instructions and the unused class codes lead to zero stall cycles;
- that a stalled store releases the hazard it was waiting on.

// File: rtl/acc_stall_pkg.sv
package acc_stall_pkg;
  localparam int NUM_ACC_DEF = 4;
  localparam int STALL_CYCLES_DEF = 2;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_MAC   = 3'd1,
    CLS_LOAD  = 3'd2,
    CLS_STORE = 3'd3,
    CLS_OTHER = 3'd4
  } acc_class_e;

  // Map a raw class code onto the enum; unused codes behave as OTHER.
  function automatic acc_class_e norm_class(input logic [2:0] raw);
    case (raw)
      3'd0: return CLS_NONE;
      3'd1: return CLS_MAC;
      3'd2: return CLS_LOAD;
      3'd3: return CLS_STORE;
      default: return CLS_OTHER;
    endcase
  endfunction

  function automatic logic writes_acc(input acc_class_e c);
    return (c == CLS_MAC) || (c == CLS_LOAD);
  endfunction
endpackage

// File: rtl/acc_hist_reg.sv
module acc_hist_reg
  import acc_stall_pkg::*;
#(
  parameter int ACC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             issue,
  input  acc_class_e       in_cls,
  input  logic [ACC_W-1:0] in_acc,
  output acc_class_e       hist_cls,
  output logic [ACC_W-1:0] hist_acc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_cls <= CLS_NONE;
      hist_acc <= '0;
    end else if (issue) begin
      hist_cls <= in_cls;
      hist_acc <= in_acc;
    end else if (!in_valid) begin
      hist_cls <= CLS_NONE;
      hist_acc <= '0;
    end
  end

  // R8: a held instruction leaves the history untouched
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !issue) |=> ($stable(hist_cls) && $stable(hist_acc)));

  // R7: a bubble removes any remembered writer
  a_r7_bubble_clears: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (hist_cls == CLS_NONE));
endmodule

// File: rtl/acc_hazard_cmp.sv
module acc_hazard_cmp
  import acc_stall_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int ACC_W = 2
) (
  input  logic             in_valid,
  input  acc_class_e       in_cls,
  input  logic [ACC_W-1:0] in_acc,
  input  acc_class_e       hist_cls,
  input  logic [ACC_W-1:0] hist_acc,
  output logic             hazard
);
  logic               prev_writer;
  logic               cur_store;
  logic [NUM_ACC-1:0] wr_hit;
  logic [NUM_ACC-1:0] rd_hit;

  assign prev_writer = writes_acc(hist_cls);
  assign cur_store   = in_valid && (in_cls == CLS_STORE);

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    assign wr_hit[i] = prev_writer && (hist_acc == ACC_W'(i));
    assign rd_hit[i] = cur_store && (in_acc == ACC_W'(i));
  end

  assign hazard = |(wr_hit & rd_hit);
endmodule

// File: rtl/acc_stall_timer.sv
module acc_stall_timer #(
  parameter int STALL_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hazard,
  output logic stall_o
);
  localparam int CW = $clog2(STALL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STALL_CYCLES);

  logic [CW-1:0] cnt;

  always_comb begin
    if (cnt == '0) stall_o = hazard;
    else           stall_o = (cnt < LAST);
  end

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (cnt == '0)      cnt <= hazard ? CW'(1) : '0;
    else if (cnt == LAST)    cnt <= '0;
    else                     cnt <= cnt + CW'(1);
  end

  // R2: the window always ends in a released cycle
  a_r2_release_at_end: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |-> !stall_o);

  // R2: a new stall starts the window at count one
  a_r2_window_starts: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && stall_o) |=> (cnt == CW'(1)));
endmodule

// File: rtl/acc_stall_ctl.sv
module acc_stall_ctl
  import acc_stall_pkg::*;
#(
  parameter int NUM_ACC = NUM_ACC_DEF,
  parameter int STALL_CYCLES = STALL_CYCLES_DEF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [2:0]                 in_class,
  input  logic [$clog2(NUM_ACC)-1:0] in_acc,
  output logic                       in_ready,
  output logic                       stall_req
);
  localparam int ACC_W = $clog2(NUM_ACC);

  acc_class_e       cls_n;
  acc_class_e       hist_cls;
  logic [ACC_W-1:0] hist_acc;
  logic             hazard;
  logic             stall;
  logic             issue;

  assign cls_n     = norm_class(in_class);
  assign issue     = in_valid && !stall;
  assign in_ready  = !stall;
  assign stall_req = stall;

  acc_hist_reg #(.ACC_W(ACC_W)) u_hist (
    .clk(clk), .rst(rst), .in_valid(in_valid), .issue(issue),
    .in_cls(cls_n), .in_acc(in_acc),
    .hist_cls(hist_cls), .hist_acc(hist_acc)
  );

  acc_hazard_cmp #(.NUM_ACC(NUM_ACC), .ACC_W(ACC_W)) u_cmp (
    .in_valid(in_valid), .in_cls(cls_n), .in_acc(in_acc),
    .hist_cls(hist_cls), .hist_acc(hist_acc), .hazard(hazard)
  );

  acc_stall_timer #(.STALL_CYCLES(STALL_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .hazard(hazard), .stall_o(stall)
  );

  // R4: a stall only begins for a store whose index matches the writer
  a_r4_stall_needs_match: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_req) |-> (cls_n == CLS_STORE && writes_acc(hist_cls)
                          && hist_acc == in_acc));

  // R5: a load-to-accumulator is never held
  a_r5_load_never_stalls: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls_n == CLS_LOAD) |-> !stall_req);
endmodule

// File: tb/acc_stall_ctl_test.sv
`timescale 1ns/100ps
module acc_stall_ctl_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [2:0] in_class;
  logic [1:0] in_acc;
  logic       in_ready;
  logic       stall_req;

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  bit m_wr;      // previous issued instruction wrote an accumulator
  int m_acc;
  int m_waited;  // stall cycles already spent by the waiting store
  bit exp_stall;

  always #2.5 clk = ~clk;

  acc_stall_ctl uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_acc(in_acc), .in_ready(in_ready), .stall_req(stall_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare outputs, then advance the model.
  task automatic step(input bit v, input int cls, input int acc, output bit issued);
    @(negedge clk);
    in_valid = v; in_class = 3'(cls); in_acc = 2'(acc);
    #1;
    exp_stall = v && cls == 3 && m_wr && acc == m_acc && m_waited < 2;
    check("R9 stall_req", int'(stall_req), int'(exp_stall));
    check("R9 in_ready", int'(in_ready), int'(!exp_stall));
    @(posedge clk);
    issued = v && !exp_stall;
    if (issued) begin
      m_wr = (cls == 1 || cls == 2); m_acc = acc; m_waited = 0;
    end else if (!v) begin
      m_wr = 0; m_waited = 0;
    end else m_waited++;
  endtask

  // Present an instruction until it issues; return the stall cycles seen.
  task automatic send(input int cls, input int acc, output int stalls);
    bit done = 0;
    stalls = 0;
    while (!done) begin
      step(1, cls, acc, done);
      if (!done) stalls++;
    end
  endtask

  task automatic bubble();
    bit d;
    step(0, 0, 0, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s;
    rst = 1; in_valid = 0; in_class = 0; in_acc = 0;
    m_wr = 0; m_acc = 0; m_waited = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: first store after reset
    send(3, 0, s); check("R1 store after reset", s, 0);
    // R2: MAC then store same accumulator
    send(1, 1, s); send(3, 1, s); check("R2 mac->store same", s, 2);
    // R3: load then store same accumulator
    send(2, 2, s); send(3, 2, s); check("R3 load->store same", s, 2);
    // R4: mismatched index
    send(1, 0, s); send(3, 3, s); check("R4 mac->store other", s, 0);
    send(2, 1, s); send(3, 2, s); check("R4 load->store other", s, 0);
    // R5: loads after writers
    send(1, 1, s); send(2, 1, s); check("R5 mac->load", s, 0);
    send(2, 0, s); check("R5 load->load", s, 0);
    // R6: mac, mac, store other -> none; same -> two
    send(1, 0, s); send(1, 0, s); send(3, 1, s); check("R6 mac mac store other", s, 0);
    send(1, 0, s); send(1, 0, s); send(3, 0, s); check("R6 mac mac store same", s, 2);
    // R7: intervening OTHER or bubble
    send(1, 2, s); send(4, 2, s); send(3, 2, s); check("R7 other between", s, 0);
    send(1, 2, s); bubble(); send(3, 2, s); check("R7 bubble between", s, 0);
    // R8: issued store is not a writer
    send(1, 3, s); send(3, 3, s); check("R8 first store", s, 2);
    send(3, 3, s); check("R8 second store", s, 0);
    // R10: unused codes act as OTHER
    send(1, 1, s); send(6, 1, s); check("R10 code6 no stall", s, 0);
    send(3, 1, s); check("R10 code6 clears", s, 0);
    send(2, 1, s); send(7, 1, s); send(3, 1, s); check("R10 code7 clears", s, 0);
    send(5, 1, s); send(3, 1, s); check("R10 code5 not writer", s, 0);
    // R2/R4 sweep over every index pair, writer as MAC or load
    for (int w = 1; w <= 2; w++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          bubble();
          send(w, a, s); send(3, b, s);
          check(a == b ? "R2 sweep match" : "R4 sweep mismatch", s, a == b ? 2 : 0);
        end
    bubble();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule